// File: doc/BRIEF.md
# Gate-Triggered Programmable Clock Divider

This block derives a slow clock from a stable reference clock. The division ratio is an 8-bit value D, and the output runs at the reference rate divided by D+1. The output runs only while an asynchronous gate input is high. Each rising edge of the gate restarts the divider from a known phase, so every gate event produces the same output waveform relative to the gate, aligned to a whole reference cycle.

The gate passes through a synchronizer and an edge detector. A rising edge loads the divide value and clears the phase counter. For D of 1 or more the output is a registered square wave. For D=0 the reference clock is passed through a latch-based clock gate, so the enable can only change while the reference is low and no runt pulses appear. When the gate drops, the output returns low and stays there. A companion one-cycle enable pulse marks the start of every output period, so logic in the reference domain can run at the divided rate without a clock crossing.

Top module: `gdiv_gated_divider`

## Requirements
- R1: For D of 1 or more, the output period is exactly D+1 reference cycles on every cycle of a gate-high interval. Each period is high for ceil((D+1)/2) cycles and low for the rest.
- R2: For D=0, the output follows the reference clock while running: high in the high phase of the reference and low in the low phase.
- R3: D=255 gives a period of 256 reference cycles, with 128 cycles high.
- R4: A gate rise set up before reference rising edge 1 makes the output and the enable pulse rise on rising edge 3. The same phase repeats for every gate event.
- R5: A gate fall set up before reference rising edge 1 forces the output and the enable pulse low from rising edge 3 onward. They stay low until the next gate rise.
- R6: The enable pulse is high for exactly one reference cycle, on the first cycle of each output period. For D=0 it is high on every running cycle.
- R7: D is captured at the gate rise. A change to D while the gate is high does not alter the running waveform.
- R8: An asynchronous active-low reset drives the output and the enable pulse low at once. A gate still high after release is treated as a fresh rising edge with R4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stable reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 8 | Divide value D; output rate is reference/(D+1) |
| gate_i | input | 1 | Asynchronous run gate |
| clk_o | output | 1 | Divided or passed-through clock |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
Inputs are driven on the falling reference edge. Outputs are sampled 1 ns after each rising edge, with rising edge 1 being the first edge after the drive. A gate rise is due on the output at edge 3: two synchronizer stages plus the output register. A gate fall takes the same three edges to clear the output. The bench model therefore counts the running phase as (edge index - 3) modulo D+1 and expects running from edge 3 through edge (high length + 2). For D=0, the low phase is also checked 1 ns after each falling edge. The enable pulse has the same latency as the divided output because both come from the same register stage.

// File: rtl/gdiv_pkg.sv
`timescale 1ns/1ps
package gdiv_pkg;
  localparam int unsigned DIV_W_DEF  = 8;
  localparam int unsigned SYNC_N_DEF = 2;

  typedef enum logic {
    MODE_DIV  = 1'b0,
    MODE_PASS = 1'b1
  } gdiv_mode_e;
endpackage

// File: rtl/gdiv_sync.sv
`timescale 1ns/1ps
module gdiv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gdiv_core.sv
`timescale 1ns/1ps
module gdiv_core #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_s_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             out_o,
  output logic             tick_o,
  output logic             pass_en_o,
  output gdiv_pkg::gdiv_mode_e mode_o
);
  import gdiv_pkg::*;

  localparam int unsigned HW = DIV_W + 1;

  logic             run_q, run_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic             out_q, out_n;
  logic             tick_q, tick_n;
  logic [HW-1:0]    hi_len;
  logic             rise;

  assign rise = gate_s_i & ~run_q;

  always_comb begin
    run_n = 1'b0;
    cnt_n = '0;
    div_n = div_q;
    if (rise) begin
      run_n = 1'b1;
      div_n = div_i;
    end else if (run_q && gate_s_i) begin
      run_n = 1'b1;
      cnt_n = (cnt_q == div_q) ? '0 : cnt_q + 1'b1;
    end
  end

  // ceil((D+1)/2) high cycles
  assign hi_len = ({1'b0, div_n} + HW'(2)) >> 1;
  assign out_n  = run_n && ({1'b0, cnt_n} < hi_len);
  assign tick_n = run_n && (cnt_n == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      div_q  <= div_n;
      out_q  <= out_n;
      tick_q <= tick_n;
    end
  end

  // enable for the clock gate, settled before the edge it applies to
  assign pass_en_o = run_n && (div_n == '0);
  assign mode_o    = (div_q == '0) ? MODE_PASS : MODE_DIV;
  assign out_o     = out_q;
  assign tick_o    = tick_q;

  // R7
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && gate_s_i) |=> $stable(div_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= div_q));

  // R6
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && div_q != '0) |=> !tick_q);

  // R6
  tick_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> out_q);

  // R5
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_s_i && !run_q) |=> (!out_q && !tick_q));
endmodule

// File: rtl/gdiv_clk_gate.sv
`timescale 1ns/1ps
module gdiv_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // transparent while clk low: enable cannot change in the high phase
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/gdiv_gated_divider.sv
`timescale 1ns/1ps
module gdiv_gated_divider #(
  parameter int unsigned DIV_W  = gdiv_pkg::DIV_W_DEF,
  parameter int unsigned SYNC_N = gdiv_pkg::SYNC_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             gate_i,
  output logic             clk_o,
  output logic             tick_o
);
  import gdiv_pkg::*;

  logic       gate_s;
  logic       div_out;
  logic       pass_en;
  logic       pass_clk;
  gdiv_mode_e mode;

  gdiv_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_i),
    .q_o   (gate_s)
  );

  gdiv_core #(.DIV_W(DIV_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_s_i (gate_s),
    .div_i    (div_i),
    .out_o    (div_out),
    .tick_o   (tick_o),
    .pass_en_o(pass_en),
    .mode_o   (mode)
  );

  gdiv_clk_gate u_cg (
    .clk_i (clk_i),
    .en_i  (pass_en),
    .gclk_o(pass_clk)
  );

  assign clk_o = (mode == MODE_PASS) ? pass_clk : div_out;
endmodule

// File: tb/gdiv_gated_divider_test.sv
`timescale 1ns/1ps
module gdiv_gated_divider_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       gate_i = 1'b0;
  logic       clk_o, tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gdiv_gated_divider uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .gate_i(gate_i),
    .clk_o (clk_o),
    .tick_o(tick_o)
  );

  always #4 clk_i = ~clk_i;

  // div, gate-high cycles, change div mid-burst
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{1,   12, 0},
    '{0,   10, 0},
    '{2,   13, 0},
    '{3,   20, 1},
    '{4,   17, 0},
    '{7,   30, 0},
    '{0,   9,  1},
    '{255, 600, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_out(int d, int p);
    if (d == 0) return 1'b1;
    return (p % (d + 1)) < ((d + 2) / 2);
  endfunction

  // starts and ends at a falling edge
  task automatic burst(input int d, input int hi, input int lo, input bit chg);
    string rq;
    rq = (d == 0) ? "R2" : (d == 255) ? "R3" : "R1";
    div_i  = 8'(d);
    gate_i = 1'b1;
    for (int n = 1; n <= hi + lo; n++) begin
      bit run;
      int p;
      @(posedge clk_i); #1;
      run = (n >= 3) && (n <= hi + 2);
      p = n - 3;
      if (!run) begin
        chk(clk_o == 1'b0, (n < 3) ? "R4" : "R5", clk_o, 0);
        chk(tick_o == 1'b0, (n < 3) ? "R4" : "R5", tick_o, 0);
      end else begin
        chk(clk_o == exp_out(d, p), (n == 3) ? "R4" : (chg ? "R7" : rq), clk_o, exp_out(d, p));
        chk(tick_o == ((p % (d + 1)) == 0), "R6", tick_o, (p % (d + 1)) == 0);
      end
      @(negedge clk_i);
      if (d == 0 && run) begin
        #1 chk(clk_o == 1'b0, "R2", clk_o, 0);
      end
      if (n == hi) gate_i = 1'b0;
      if (n == 3 && chg) div_i = 8'(d ^ 8'h05);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    #1 chk(clk_o == 1'b0 && tick_o == 1'b0, "R8", {clk_o, tick_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_i); #1;
      chk(clk_o == 1'b0 && tick_o == 1'b0, "R8", {clk_o, tick_o}, 0);
    end
    @(negedge clk_i);

    for (int v = 0; v < NV; v++)
      burst(VEC[v][0], VEC[v][1], 5, VEC[v][2] != 0);

    // R4: phase repeats on back-to-back events
    burst(3, 9, 4, 1'b0);
    burst(3, 9, 4, 1'b0);

    // R8: async reset mid-burst, gate still high after release
    div_i  = 8'd3;
    gate_i = 1'b1;
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk(clk_o == 1'b0 && tick_o == 1'b0, "R8", {clk_o, tick_o}, 0);
    @(posedge clk_i); #1;
    chk(clk_o == 1'b0 && tick_o == 1'b0, "R8", {clk_o, tick_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      int p;
      @(posedge clk_i); #1;
      p = n - 3;
      if (n < 3) chk(clk_o == 1'b0, "R8", clk_o, 0);
      else chk(clk_o == exp_out(3, p), "R8", clk_o, exp_out(3, p));
      @(negedge clk_i);
    end
    gate_i = 1'b0;
    repeat (4) @(negedge clk_i);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule